// File: doc/BRIEF.md
# Registered Wired-OR Bus Transceiver

This block is a narrow bidirectional transceiver slice for a shared wired-OR bus. Each bit has two data inputs, a transmit register, a drive-high request toward the bus and a receive register that samples the resolved bus. The word offered for transmission is the bitwise OR of the two data inputs. Two active-low load controls decide whether the transmit register takes that word or keeps its value. A separate registered enable, set from two enable inputs, decides whether any bus bit may be driven.

A bus bit is never driven low. A transmit zero, or a disabled transceiver, releases the line. Any number of transceivers can therefore share one line, and the line reads high when any of them requests high. The resolved bus value comes back on `bus_in`. It is ANDed with a receive gate and captured into the receive register.

Every register updates on a rising edge of the OR of two clock inputs, so either clock can advance the block. A synchronous active-high reset clears the data registers and leaves the bus released.

Top module: `bxcv_top`

## Requirements
- R1: With `rst` high at an active edge, the transmit and receive registers clear to zero and the enable register goes to disabled, so `bus_drive` and `rx_q` read all zeros after that edge.
- R2: At an active edge, when `ld_n_a` or `ld_n_b` is low, the transmit register loads `din_a | din_b`.
- R3: At an active edge, when `ld_n_a` and `ld_n_b` are both high, the transmit register keeps its value whatever the data inputs are.
- R4: The enable register loads `drv_en_a | drv_en_b` at an active edge. A change on the enable inputs between edges leaves `bus_drive` unchanged until the next edge.
- R5: `bus_drive[i]` is 1 only when the enable register is set and transmit bit i is 1. A 1 means drive high and a 0 means release the line. The block never requests a low level.
- R6: At an active edge, `rx_q` loads `bus_in` when `rx_gate` is high and loads all zeros when `rx_gate` is low.
- R7: A rising edge on `clk_a` alone or on `clk_b` alone updates every register. When neither clock rises, every register keeps its value.
- R8: When several transceivers share one line resolved as the OR of their `bus_drive` outputs, each gated receiver captures the OR of all drive-high requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First clock input; its rising edges are active edges |
| clk_b | input | 1 | Second clock input; its rising edges are active edges |
| rst | input | 1 | Synchronous active-high reset |
| din_a | input | WIDTH | First data word |
| din_b | input | WIDTH | Second data word, ORed with `din_a` |
| ld_n_a | input | 1 | Active-low transmit load control, first |
| ld_n_b | input | 1 | Active-low transmit load control, second |
| drv_en_a | input | 1 | Bus enable request, first |
| drv_en_b | input | 1 | Bus enable request, second |
| rx_gate | input | 1 | Receive gate; 0 forces zeros into the receive register |
| bus_in | input | WIDTH | Resolved shared bus value |
| bus_drive | output | WIDTH | Per-bit drive-high request (1 = drive high, 0 = released) |
| rx_q | output | WIDTH | Receive register |

## Verification
The assertions assume that `clk_a` and `clk_b` combine into a glitch-free clock. This means a clock input changes only while the other input is not producing an edge. The bench gates a single 125 MHz source onto either input and changes the selection only while that source is low. The assertions also assume that `bus_in` is steady at each edge. In the bench the bus is resolved from registered `bus_drive` outputs, and all control and data inputs change on the falling edge of the source clock. The bench checks the outputs against its model just before every rising edge as well as after it, so a registered control that leaked through combinationally would show up.

// File: rtl/bxcv_pkg.sv
package bxcv_pkg;

    // State held by one bit slice
    typedef struct packed {
        logic tx;   // transmit register bit
        logic rx;   // receive register bit
    } slice_st_t;

endpackage

// File: rtl/bxcv_clk_merge.sv
module bxcv_clk_merge (
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_m
);
    // Either input's rising edge is an active edge for every register
    assign clk_m = clk_a | clk_b;
endmodule

// File: rtl/bxcv_ctrl.sv
module bxcv_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ld_n_a,
    input  logic ld_n_b,
    input  logic drv_en_a,
    input  logic drv_en_b,
    output logic load,
    output logic en_q
);
    logic en_d;

    // Loading happens when any active-low control is asserted
    assign load = ~(ld_n_a & ld_n_b);

    always_comb begin
        en_d = en_q;
        if (rst) en_d = 1'b0;
        else     en_d = drv_en_a | drv_en_b;
    end

    always_ff @(posedge clk) begin
        en_q <= en_d;
    end

    // R4: both enable requests low at an edge releases the bus afterwards
    p_en_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!drv_en_a && !drv_en_b) |=> !en_q);
    // R4: any enable request high at an edge arms the bus afterwards
    p_en_on_r4: assert property (@(posedge clk) disable iff (rst)
        (drv_en_a || drv_en_b) |=> en_q);
endmodule

// File: rtl/bxcv_slice.sv
module bxcv_slice
    import bxcv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic a,
    input  logic b,
    input  logic en,
    input  logic rx_gate,
    input  logic bus_bit,
    output logic tx_bit,
    output logic drive,
    output logic rx_bit
);
    slice_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.tx = 1'b0;
            st_d.rx = 1'b0;
        end else begin
            if (load) st_d.tx = a | b;
            st_d.rx = bus_bit & rx_gate;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tx_bit = st_q.tx;
    assign rx_bit = st_q.rx;
    // Only a high level is ever requested; zero means released
    assign drive  = en & st_q.tx;

    // R6: a closed receive gate captures zero
    p_rx_closed_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_gate |=> !rx_bit);
    // R6: an open receive gate follows the bus
    p_rx_open_r6: assert property (@(posedge clk) disable iff (rst)
        rx_gate |=> (rx_bit == $past(bus_bit)));
endmodule

// File: rtl/bxcv_top.sv
module bxcv_top #(
    parameter int WIDTH = 3
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst,
    input  logic [WIDTH-1:0] din_a,
    input  logic [WIDTH-1:0] din_b,
    input  logic             ld_n_a,
    input  logic             ld_n_b,
    input  logic             drv_en_a,
    input  logic             drv_en_b,
    input  logic             rx_gate,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_drive,
    output logic [WIDTH-1:0] rx_q
);
    localparam int LAST = WIDTH - 1;

    logic             clk_m;
    logic             load;
    logic             en_q;
    logic [LAST:0]    tx_vec;

    bxcv_clk_merge u_clk (
        .clk_a (clk_a),
        .clk_b (clk_b),
        .clk_m (clk_m)
    );

    bxcv_ctrl u_ctrl (
        .clk      (clk_m),
        .rst      (rst),
        .ld_n_a   (ld_n_a),
        .ld_n_b   (ld_n_b),
        .drv_en_a (drv_en_a),
        .drv_en_b (drv_en_b),
        .load     (load),
        .en_q     (en_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bxcv_slice u_slice (
            .clk     (clk_m),
            .rst     (rst),
            .load    (load),
            .a       (din_a[i]),
            .b       (din_b[i]),
            .en      (en_q),
            .rx_gate (rx_gate),
            .bus_bit (bus_in[i]),
            .tx_bit  (tx_vec[i]),
            .drive   (bus_drive[i]),
            .rx_bit  (rx_q[i])
        );
    end

    // R1: reset leaves everything cleared and the bus released
    p_reset_r1: assert property (@(posedge clk_m)
        rst |=> (tx_vec == '0 && rx_q == '0 && bus_drive == '0 && !en_q));
    // R2: a low load control captures the ORed data word
    p_tx_load_r2: assert property (@(posedge clk_m) disable iff (rst)
        (!ld_n_a || !ld_n_b) |=> (tx_vec == $past(din_a | din_b)));
    // R3: both load controls high keep the transmit word
    p_tx_hold_r3: assert property (@(posedge clk_m) disable iff (rst)
        (ld_n_a && ld_n_b) |=> $stable(tx_vec));
    // R5: a drive request needs the enable and a transmit one
    p_drive_en_r5: assert property (@(posedge clk_m) disable iff (rst)
        (bus_drive != '0) |-> en_q);
    p_drive_tx_r5: assert property (@(posedge clk_m) disable iff (rst)
        (bus_drive & ~tx_vec) == '0);
endmodule

// File: tb/sim_bxcv_top.sv
module sim_bxcv_top;
    localparam int W = 3;
    localparam int N = 3;

    logic clk = 1'b0;
    logic sel_a = 1'b1, sel_b = 1'b0;
    logic rst = 1'b1;
    logic ck_a, ck_b;
    logic [W-1:0] a [N];
    logic [W-1:0] b [N];
    logic ldna [N], ldnb [N], ena [N], enb [N];
    logic gate [N];
    logic [W-1:0] drv [N];
    logic [W-1:0] rxq [N];
    logic [W-1:0] bus;

    int checks = 0, fails = 0;
    // reference state
    logic [W-1:0] m_tx [N];
    logic [W-1:0] m_rx [N];
    logic         m_en [N];

    always #4 clk = ~clk;   // 125 MHz
    assign ck_a = clk & sel_a;
    assign ck_b = clk & sel_b;
    assign bus  = drv[0] | drv[1] | drv[2];

    bxcv_top #(.WIDTH(W)) u0 (.clk_a(ck_a), .clk_b(ck_b), .rst(rst),
        .din_a(a[0]), .din_b(b[0]), .ld_n_a(ldna[0]), .ld_n_b(ldnb[0]),
        .drv_en_a(ena[0]), .drv_en_b(enb[0]), .rx_gate(gate[0]),
        .bus_in(bus), .bus_drive(drv[0]), .rx_q(rxq[0]));
    bxcv_top #(.WIDTH(W)) u1 (.clk_a(ck_a), .clk_b(ck_b), .rst(rst),
        .din_a(a[1]), .din_b(b[1]), .ld_n_a(ldna[1]), .ld_n_b(ldnb[1]),
        .drv_en_a(ena[1]), .drv_en_b(enb[1]), .rx_gate(gate[1]),
        .bus_in(bus), .bus_drive(drv[1]), .rx_q(rxq[1]));
    bxcv_top #(.WIDTH(W)) u2 (.clk_a(ck_a), .clk_b(ck_b), .rst(rst),
        .din_a(a[2]), .din_b(b[2]), .ld_n_a(ldna[2]), .ld_n_b(ldnb[2]),
        .drv_en_a(ena[2]), .drv_en_b(enb[2]), .rx_gate(gate[2]),
        .bus_in(bus), .bus_drive(drv[2]), .rx_q(rxq[2]));

    task automatic chk(input string tag, input int inst,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst %0d actual %b expected %b", tag, inst, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < N; i++) begin
            chk({tag, " drive"}, i, drv[i], m_en[i] ? m_tx[i] : '0);
            chk({tag, " rx"}, i, rxq[i], m_rx[i]);
        end
    endtask

    // Inputs are already set (changed at a falling edge). Check before the
    // rising edge, let it pass, advance the model, check again.
    task automatic step(input string tag);
        logic [W-1:0] busv;
        logic edge_on;
        edge_on = sel_a | sel_b;
        #1 compare({tag, " pre"});
        @(posedge clk);
        @(negedge clk);
        busv = '0;
        for (int i = 0; i < N; i++) busv |= m_en[i] ? m_tx[i] : '0;
        if (edge_on) begin
            for (int i = 0; i < N; i++) begin
                if (rst) begin
                    m_tx[i] = '0; m_rx[i] = '0; m_en[i] = 1'b0;
                end else begin
                    m_rx[i] = gate[i] ? busv : '0;
                    if (!(ldna[i] && ldnb[i])) m_tx[i] = a[i] | b[i];
                    m_en[i] = ena[i] | enb[i];
                end
            end
        end
        compare(tag);
    endtask

    task automatic idle_all();
        for (int i = 0; i < N; i++) begin
            a[i] = '0; b[i] = '0; ldna[i] = 1'b1; ldnb[i] = 1'b1;
            ena[i] = 1'b0; enb[i] = 1'b0; gate[i] = 1'b1;
        end
    endtask

    initial begin
        #800000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle_all();
        for (int i = 0; i < N; i++) begin m_tx[i] = '0; m_rx[i] = '0; m_en[i] = 1'b0; end
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset state after a reset edge
        rst = 1'b1;
        step("R1 reset");
        step("R1 reset");
        rst = 1'b0;

        // R2: load from din_a only, low on first load control
        a[0] = 3'b101; ldna[0] = 1'b0;
        ena[0] = 1'b1;
        step("R2 load a");
        // R5: enable now set, drive follows transmit ones only
        ldna[0] = 1'b1; a[0] = 3'b000;
        step("R5 drive");
        // R2: load from din_b on instance 1 via second control
        b[1] = 3'b010; ldnb[1] = 1'b0; enb[1] = 1'b1;
        step("R2 load b");
        ldnb[1] = 1'b1; b[1] = '0;
        // R8: wired-OR of instances 0 and 1 seen by every receiver
        step("R8 wired or");
        step("R8 wired or");

        // R3: both controls high, data changes ignored
        a[0] = 3'b010; b[0] = 3'b010;
        step("R3 hold");
        step("R3 hold");
        // R2: both sources ORed
        ldna[2] = 1'b0; ldnb[2] = 1'b0; a[2] = 3'b001; b[2] = 3'b100;
        ena[2] = 1'b1;
        step("R2 or data");
        ldna[2] = 1'b1; ldnb[2] = 1'b1;
        step("R8 three drivers");

        // R4: enables dropped only after the edge (pre-check covers gap)
        ena[0] = 1'b0; enb[1] = 1'b0;
        step("R4 enable off");
        step("R4 enable off");
        // R6: closed receive gate loads zeros despite a busy bus
        gate[1] = 1'b0;
        step("R6 gate closed");
        gate[1] = 1'b1;
        step("R6 gate open");

        // R7: second clock alone advances state
        sel_a = 1'b0; sel_b = 1'b1;
        ena[0] = 1'b1; ldna[1] = 1'b0; a[1] = 3'b111;
        step("R7 clk_b");
        ldna[1] = 1'b1;
        step("R7 clk_b");
        // R7: no clock, nothing moves even with changes offered
        sel_b = 1'b0;
        ldna[0] = 1'b0; a[0] = 3'b000; ena[2] = 1'b0; gate[0] = 1'b0;
        step("R7 no clock");
        step("R7 no clock");
        sel_a = 1'b1;
        step("R7 clk_a back");
        ldna[0] = 1'b1; gate[0] = 1'b1;
        step("R7 clk_a back");

        // R1: reset in the middle of traffic
        rst = 1'b1;
        step("R1 mid reset");
        rst = 1'b0;
        step("R1 after reset");

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule